// File: doc/BRIEF.md
# Chip-bus DMA slot arbiter

This block shares one memory bus between several direct-memory-access clients by handing out the bus one slot at a time, in step with the raster beam. It keeps a slot counter that steps once per clock across a line, and a line counter that steps at the end of each line and wraps at the end of a frame. For every slot it names exactly one owner: bitplane fetch, disk, the display coprocessor, the blitter or the CPU. The slot can also be left idle. The owner depends on the slot's parity, on its position within the line and on a fixed priority order.

Bitplane fetch is gated by two window flags. A horizontal flag turns on and off at programmable slot numbers. A vertical flag turns on and off at programmable line numbers. Each client's DMA is switched by its own bit in a control word and by a master bit in the same word. The CPU is never switched off. The block also reports the beam position with each grant, offers the coprocessor a comparison word, strobes the coprocessor to stop while its DMA is off, and raises a one-cycle interrupt at the end of every frame.

All outputs are registered. The values seen in a given cycle describe one slot: its grant, its position and its strobes. That slot's arbitration used the inputs present at the clock edge that opened the cycle.

Top module: `dma_slot_arbiter`

## Requirements
- R1: The slot counter runs from 0 to LINE_SLOTS-1 and then wraps. The line counter steps when the slot counter wraps and runs from 0 to FRAME_LINES-1. `beam_pos` is {line[7:0], slot[7:0]} of the slot whose grant is shown in the same cycle. The first slot after reset is line 0, slot 0.
- R2: `vblank_irq` is high for exactly the one output cycle that shows the last slot of the last line. In that same cycle `frame_count` shows its previous value plus one.
- R3: The control word holds the bits [4] master, [3] bitplane, [2] coprocessor, [1] blitter and [0] disk. A client's DMA counts as enabled only when both its own bit and the master bit are 1.
- R4: For slot s, the horizontal flag is (held | s==hwin_start) & s!=hwin_stop. The result is used for slot s and is stored as the held value for the next slot, on every slot.
- R5: When the line counter steps to line n (including the wrap to 0), the vertical flag becomes (previous | n==vwin_start) & n!=vwin_stop. It then holds for the whole of line n. Reset clears both flags.
- R6: Bitplane fetch (grant bit 0) takes any slot in which the horizontal flag, the vertical flag and bitplane DMA enable are all true.
- R7: An odd slot numbered DISK_FIRST to DISK_LAST goes to disk (grant bit 1) when bitplanes do not take it, disk DMA is enabled and `disk_req` is high.
- R8: An even slot not taken by bitplanes goes to the coprocessor (grant bit 2) when its DMA is enabled and `cop_req` is high in that slot. `cop_pos` is {line[7:0], slot[7:0] & 8'hFE}.
- R9: `cop_stop` is high for an even slot not taken by bitplanes while coprocessor DMA is disabled. It never coincides with a coprocessor grant.
- R10: A slot left by the clients above goes to the blitter (grant bit 3) when its DMA is enabled and `blt_req` is high. Otherwise it goes to the CPU (grant bit 4) when `cpu_req` is high. Otherwise the grant is all zeros. At most one grant bit is ever set.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_ctrl | input | 5 | DMA control word (R3 layout) |
| hwin_start | input | SLOT_W | Slot at which the horizontal fetch flag turns on |
| hwin_stop | input | SLOT_W | Slot at which the horizontal fetch flag turns off |
| vwin_start | input | LINE_W | Line at which the vertical fetch flag turns on |
| vwin_stop | input | LINE_W | Line at which the vertical fetch flag turns off |
| disk_req | input | 1 | Disk controller wants a slot |
| cop_req | input | 1 | Coprocessor wants the offered slot |
| blt_req | input | 1 | Blitter wants a slot |
| cpu_req | input | 1 | CPU wants a slot |
| grant | output | 5 | One-hot owner of the slot shown; zero when idle |
| beam_pos | output | 16 | {line[7:0], slot[7:0]} of the slot shown |
| cop_pos | output | 16 | Beam comparison word offered to the coprocessor |
| cop_stop | output | 1 | Stop strobe to the coprocessor |
| vblank_irq | output | 1 | End-of-frame interrupt pulse |
| frame_count | output | FRAME_W | Frames completed since reset |

## Verification
The bench builds the block with LINE_SLOTS=20 and FRAME_LINES=12. With those values one frame takes 240 cycles, so several complete frames, their line wraps and their end-of-frame pulses all fit in a short run. Each frame uses a different control word and a different window set. Among them are windows that wrap across the end of a line and across the end of a frame, a frame with the master bit off, and a frame with no requests at all. Every slot's expected owner comes from an independent model of the priority rules.

// File: rtl/dma_slot_pkg.sv
package dma_slot_pkg;

  // Grant vector layout (one-hot, zero = idle slot)
  localparam int GNT_N   = 5;
  localparam int GNT_BPL = 0;
  localparam int GNT_DSK = 1;
  localparam int GNT_COP = 2;
  localparam int GNT_BLT = 3;
  localparam int GNT_CPU = 4;

  // DMA control word layout
  localparam int CTRL_W   = 5;
  localparam int CTRL_DSK = 0;
  localparam int CTRL_BLT = 1;
  localparam int CTRL_COP = 2;
  localparam int CTRL_BPL = 3;
  localparam int CTRL_MST = 4;

  typedef logic [GNT_N-1:0]  grant_t;
  typedef logic [CTRL_W-1:0] ctrl_t;

endpackage

// File: rtl/dma_beam_counter.sv
module dma_beam_counter #(
  parameter int LINE_SLOTS  = 227,
  parameter int FRAME_LINES = 312,
  localparam int SLOT_W = $clog2(LINE_SLOTS),
  localparam int LINE_W = $clog2(FRAME_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic [LINE_W-1:0] line,
  output logic              line_end,
  output logic              frame_end,
  output logic [LINE_W-1:0] line_next
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(LINE_SLOTS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(FRAME_LINES - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [LINE_W-1:0] line_q, line_d;

  always_comb begin
    line_end  = (slot_q == SLOT_LAST);
    frame_end = line_end && (line_q == LINE_LAST);
    line_next = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
    slot_d    = line_end ? '0 : slot_q + 1'b1;
    line_d    = line_end ? line_next : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      line_q <= '0;
    end else begin
      slot_q <= slot_d;
      line_q <= line_d;
    end
  end

  assign slot = slot_q;
  assign line = line_q;

endmodule

// File: rtl/dma_window_flag.sv
module dma_window_flag #(
  parameter int W          = 8,
  parameter bit REGISTERED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] stop,
  output logic         flag
);

  logic held_q, eval;

  always_comb begin
    eval = (held_q || (pos == start)) && (pos != stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (upd) begin
      held_q <= eval;
    end
  end

  generate
    if (REGISTERED) begin : g_held
      assign flag = held_q;
    end else begin : g_live
      assign flag = eval;
    end
  endgenerate

endmodule

// File: rtl/dma_slot_select.sv
module dma_slot_select
  import dma_slot_pkg::*;
#(
  parameter int SLOT_W     = 8,
  parameter int DISK_FIRST = 4,
  parameter int DISK_LAST  = 6
) (
  input  logic [SLOT_W-1:0] slot,
  input  ctrl_t             ctrl,
  input  logic              h_on,
  input  logic              v_on,
  input  logic              disk_req,
  input  logic              cop_req,
  input  logic              blt_req,
  input  logic              cpu_req,
  output grant_t            grant,
  output logic              cop_stop
);

  logic master, en_bpl, en_dsk, en_cop, en_blt;
  logic odd, in_disk, fetch;

  always_comb begin
    master  = ctrl[CTRL_MST];
    en_bpl  = master && ctrl[CTRL_BPL];
    en_dsk  = master && ctrl[CTRL_DSK];
    en_cop  = master && ctrl[CTRL_COP];
    en_blt  = master && ctrl[CTRL_BLT];
    odd     = slot[0];
    in_disk = (int'(slot) >= DISK_FIRST) && (int'(slot) <= DISK_LAST);
    fetch   = h_on && v_on && en_bpl;

    grant    = '0;
    cop_stop = 1'b0;
    if (fetch) begin
      grant[GNT_BPL] = 1'b1;
    end else if (odd && in_disk && en_dsk && disk_req) begin
      grant[GNT_DSK] = 1'b1;
    end else if (!odd && en_cop && cop_req) begin
      grant[GNT_COP] = 1'b1;
    end else if (en_blt && blt_req) begin
      grant[GNT_BLT] = 1'b1;
    end else if (cpu_req) begin
      grant[GNT_CPU] = 1'b1;
    end
    if (!fetch && !odd && !en_cop) begin
      cop_stop = 1'b1;
    end
  end

endmodule

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter
  import dma_slot_pkg::*;
#(
  parameter int LINE_SLOTS  = 227,
  parameter int FRAME_LINES = 312,
  parameter int DISK_FIRST  = 4,
  parameter int DISK_LAST   = 6,
  parameter int FRAME_W     = 8,
  localparam int SLOT_W = $clog2(LINE_SLOTS),
  localparam int LINE_W = $clog2(FRAME_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4:0]         dma_ctrl,
  input  logic [SLOT_W-1:0]  hwin_start,
  input  logic [SLOT_W-1:0]  hwin_stop,
  input  logic [LINE_W-1:0]  vwin_start,
  input  logic [LINE_W-1:0]  vwin_stop,
  input  logic               disk_req,
  input  logic               cop_req,
  input  logic               blt_req,
  input  logic               cpu_req,
  output logic [4:0]         grant,
  output logic [15:0]        beam_pos,
  output logic [15:0]        cop_pos,
  output logic               cop_stop,
  output logic               vblank_irq,
  output logic [FRAME_W-1:0] frame_count
);

  logic [SLOT_W-1:0] slot;
  logic [LINE_W-1:0] line, line_next;
  logic              line_end, frame_end;
  logic              h_on, v_on;
  grant_t            grant_d;
  logic              stop_d;

  dma_beam_counter #(
    .LINE_SLOTS (LINE_SLOTS),
    .FRAME_LINES(FRAME_LINES)
  ) u_beam (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot     (slot),
    .line     (line),
    .line_end (line_end),
    .frame_end(frame_end),
    .line_next(line_next)
  );

  dma_window_flag #(.W(SLOT_W), .REGISTERED(1'b0)) u_hwin (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (1'b1),
    .pos  (slot),
    .start(hwin_start),
    .stop (hwin_stop),
    .flag (h_on)
  );

  dma_window_flag #(.W(LINE_W), .REGISTERED(1'b1)) u_vwin (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (line_end),
    .pos  (line_next),
    .start(vwin_start),
    .stop (vwin_stop),
    .flag (v_on)
  );

  dma_slot_select #(
    .SLOT_W    (SLOT_W),
    .DISK_FIRST(DISK_FIRST),
    .DISK_LAST (DISK_LAST)
  ) u_sel (
    .slot    (slot),
    .ctrl    (dma_ctrl),
    .h_on    (h_on),
    .v_on    (v_on),
    .disk_req(disk_req),
    .cop_req (cop_req),
    .blt_req (blt_req),
    .cpu_req (cpu_req),
    .grant   (grant_d),
    .cop_stop(stop_d)
  );

  // Output stage next-state
  logic [7:0]         line8, slot8;
  logic [15:0]        beam_d, cpos_d;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    line8   = 8'(line);
    slot8   = 8'(slot);
    beam_d  = {line8, slot8};
    cpos_d  = {line8, slot8 & 8'hFE};
    frame_d = frame_count + FRAME_W'(frame_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      beam_pos    <= '0;
      cop_pos     <= '0;
      cop_stop    <= 1'b0;
      vblank_irq  <= 1'b0;
      frame_count <= '0;
    end else begin
      grant       <= grant_d;
      beam_pos    <= beam_d;
      cop_pos     <= cpos_d;
      cop_stop    <= stop_d;
      vblank_irq  <= frame_end;
      frame_count <= frame_d;
    end
  end

endmodule

// File: rtl/dma_slot_arbiter_chk.sv
module dma_slot_arbiter_chk #(
  parameter int LINE_SLOTS = 227,
  parameter int DISK_FIRST = 4,
  parameter int DISK_LAST  = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  dma_ctrl,
  input logic [4:0]  grant,
  input logic [15:0] beam_pos,
  input logic        cop_stop,
  input logic        vblank_irq
);

  localparam logic [7:0] SLOT_LAST = 8'(LINE_SLOTS - 1);

  logic [1:0] age_q;
  logic       primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  assign primed = (age_q >= 2'd2);

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (beam_pos[7:0] != SLOT_LAST) |=> (beam_pos[7:0] == $past(beam_pos[7:0]) + 8'd1));

  // R2
  irq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    vblank_irq |=> (beam_pos == 16'd0));

  // R2
  irq_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (beam_pos[7:0] == SLOT_LAST));

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  bpl_enable_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    grant[0] |-> ($past(dma_ctrl[3]) && $past(dma_ctrl[4])));

  // R7
  disk_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[1] |-> (beam_pos[0] && (int'(beam_pos[7:0]) >= DISK_FIRST)
                  && (int'(beam_pos[7:0]) <= DISK_LAST)));

  // R8
  cop_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[2] |-> !beam_pos[0]);

  // R9
  stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_stop |-> (!grant[2] && !grant[0] && !beam_pos[0]));

endmodule

bind dma_slot_arbiter dma_slot_arbiter_chk #(
  .LINE_SLOTS(LINE_SLOTS),
  .DISK_FIRST(DISK_FIRST),
  .DISK_LAST (DISK_LAST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dma_ctrl  (dma_ctrl),
  .grant     (grant),
  .beam_pos  (beam_pos),
  .cop_stop  (cop_stop),
  .vblank_irq(vblank_irq)
);

// File: tb/sim_dma_slot_arbiter.sv
`timescale 1ns/1ps
module sim_dma_slot_arbiter;

  localparam int LS = 20;
  localparam int FL = 12;
  localparam int SW = $clog2(LS);
  localparam int LW = $clog2(FL);
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    dma_ctrl;
  logic [SW-1:0] hwin_start, hwin_stop;
  logic [LW-1:0] vwin_start, vwin_stop;
  logic          disk_req, cop_req, blt_req, cpu_req;
  logic [4:0]    grant;
  logic [15:0]   beam_pos, cop_pos;
  logic          cop_stop, vblank_irq;
  logic [FW-1:0] frame_count;

  always #4 clk = ~clk;

  dma_slot_arbiter #(
    .LINE_SLOTS (LS),
    .FRAME_LINES(FL),
    .DISK_FIRST (4),
    .DISK_LAST  (6),
    .FRAME_W    (FW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .dma_ctrl(dma_ctrl),
    .hwin_start(hwin_start), .hwin_stop(hwin_stop),
    .vwin_start(vwin_start), .vwin_stop(vwin_stop),
    .disk_req(disk_req), .cop_req(cop_req), .blt_req(blt_req), .cpu_req(cpu_req),
    .grant(grant), .beam_pos(beam_pos), .cop_pos(cop_pos), .cop_stop(cop_stop),
    .vblank_irq(vblank_irq), .frame_count(frame_count)
  );

  typedef struct {
    logic [4:0]    g;
    logic [15:0]   beam;
    logic [15:0]   cpos;
    logic          stop;
    logic          irq;
    logic [FW-1:0] frame;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  // independent reference state
  int   mh = 0, mv = 0, cyc = 0;
  bit   mhq = 0, mvq = 0;
  logic [FW-1:0] mframe = '0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Driver: set inputs for one slot, push its expected outputs, advance the model
  task automatic drive_slot(logic [4:0] ctrl, int hs, int he, int vs, int ve,
                            logic [3:0] m, string ftag);
    exp_t e;
    bit en_b, en_d, en_c, en_t, hf, fetch, odd, nvq;
    int nv;
    dma_ctrl   = ctrl;
    hwin_start = SW'(hs);
    hwin_stop  = SW'(he);
    vwin_start = LW'(vs);
    vwin_stop  = LW'(ve);
    disk_req   = m[0] & ~cyc[3];
    cop_req    = m[1] &  cyc[1];
    blt_req    = m[2] & (cyc[0] | cyc[2]);
    cpu_req    = m[3];

    en_b  = ctrl[4] & ctrl[3];
    en_c  = ctrl[4] & ctrl[2];
    en_t  = ctrl[4] & ctrl[1];
    en_d  = ctrl[4] & ctrl[0];
    hf    = (mhq || mh == hs) && mh != he;
    fetch = hf && mvq && en_b;
    odd   = (mh % 2) == 1;

    e.g = 5'b0;
    if (fetch)                                         begin e.g = 5'b00001; e.tag = {"R6 R4 R5 ", ftag}; end
    else if (odd && mh >= 4 && mh <= 6 && en_d && disk_req) begin e.g = 5'b00010; e.tag = {"R7 ", ftag}; end
    else if (!odd && en_c && cop_req)                  begin e.g = 5'b00100; e.tag = {"R8 ", ftag}; end
    else if (en_t && blt_req)                          begin e.g = 5'b01000; e.tag = {"R10 ", ftag}; end
    else if (cpu_req)                                  begin e.g = 5'b10000; e.tag = {"R10 ", ftag}; end
    else                                               e.tag = {"R10 idle ", ftag};
    e.beam  = {8'(mv), 8'(mh)};
    e.cpos  = {8'(mv), 8'(mh) & 8'hFE};
    e.stop  = !fetch && !odd && !en_c;
    e.irq   = (mh == LS-1) && (mv == FL-1);
    e.frame = mframe + FW'(e.irq);
    exp_q.push_back(e);

    mframe = e.frame;
    mhq    = hf;
    if (mh == LS-1) begin
      mh  = 0;
      nv  = (mv == FL-1) ? 0 : mv + 1;
      nvq = (mvq || nv == vs) && nv != ve;
      mvq = nvq;
      mv  = nv;
    end else begin
      mh++;
    end
    cyc++;
  endtask

  // Monitor: compare the registered outputs away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp({"grant ", e.tag}, 32'(grant), 32'(e.g));
      cmp("R1 beam_pos", 32'(beam_pos), 32'(e.beam));
      cmp("R8 cop_pos", 32'(cop_pos), 32'(e.cpos));
      cmp("R9 cop_stop", 32'(cop_stop), 32'(e.stop));
      cmp("R2 vblank_irq", 32'(vblank_irq), 32'(e.irq));
      cmp("R2 frame_count", 32'(frame_count), 32'(e.frame));
    end
  end

  task automatic check_reset_outputs();
    cmp("R11 grant", 32'(grant), 32'd0);
    cmp("R11 beam_pos", 32'(beam_pos), 32'd0);
    cmp("R11 cop_pos", 32'(cop_pos), 32'd0);
    cmp("R11 cop_stop", 32'(cop_stop), 32'd0);
    cmp("R11 vblank_irq", 32'(vblank_irq), 32'd0);
    cmp("R11 frame_count", 32'(frame_count), 32'd0);
  endtask

  task automatic run_frame(logic [4:0] ctrl, int hs, int he, int vs, int ve,
                           logic [3:0] m, string ftag);
    for (int i = 0; i < LS*FL; i++) begin
      drive_slot(ctrl, hs, he, vs, ve, m, ftag);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    dma_ctrl = '0; hwin_start = '0; hwin_stop = '0; vwin_start = '0; vwin_stop = '0;
    disk_req = 0; cop_req = 0; blt_req = 0; cpu_req = 0;
    repeat (3) @(negedge clk);
    check_reset_outputs();
    rst_n = 1'b1;
    // all clients on, window inside the frame
    run_frame(5'b11111, 6, 14, 2, 8, 4'b1111, "R3 all-on");
    // master off: own bits ignored, only the CPU wins
    run_frame(5'b01111, 6, 14, 2, 8, 4'b1111, "R3 master-off");
    // disk bit off, full-width window
    run_frame(5'b11110, 0, 19, 0, 11, 4'b1111, "R3 R7 disk-off");
    // coprocessor off, windows wrapping across line and frame ends
    run_frame(5'b11011, 15, 3, 9, 3, 4'b1111, "R9 R4 R5 wrap");
    // bitplanes off, no blitter or CPU requests: idle slots
    run_frame(5'b10111, 6, 14, 2, 8, 4'b0011, "R10 partial");
    // start equals stop: horizontal flag never rises; nothing requests
    run_frame(5'b11111, 5, 5, 0, 11, 4'b0000, "R10 R6 none");
    @(posedge clk);
    #3;
    cmp("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
    rst_n = 1'b0;
    #1;
    check_reset_outputs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule